// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block runs one serial flash command each time software writes its command register. A command goes out as a string of bytes on a single-bit serial link: an opcode byte, an optional address of up to three bytes, an optional run of zero-valued dummy bytes, and up to four data bytes. The data bytes are either sent from the data register or received into it. The command word gives the length of each phase, the transfer direction, which chip select to drive, and whether that chip select stays asserted once the command ends.

Software places the address and the outgoing data in their registers and then writes the command word. It polls the pending flag in the status register until the flag clears. For a read it then collects the received bytes from the data register. Software can chain commands inside one chip-select frame by setting the keep bit. A command issued while the frame is still held leaves out its opcode byte and goes straight to its address, dummy and data phases. A later command with the keep bit clear closes the frame. The serial clock idles high. Outgoing bits change on its falling edge and incoming bits are taken on its rising edge, most significant bit first.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the status register reads zero, every chip-select output is high (inactive), the serial clock is high and the serial data output is low.
- R2: Register offsets on `reg_addr` are 0 command, 1 address, 2 data and 3 status. The address register reads back only its low 24 bits. The data register reads back all 32 bits. The command register reads back the last command word that was accepted.
- R3: An accepted command first sends its opcode (command bits [7:0]). It then sends the address length (bits [22:20], any value above 3 treated as 3) in bytes of the address register, the highest byte first. Every byte goes out most significant bit first.
- R4: After the address, the command sends as many 0x00 bytes as the dummy length in command bits [19:16] (0 to 15).
- R5: When command bit 8 is 1, the command then sends the data length (bits [11:9], any value above 4 treated as 4) in bytes. Data byte k is taken from data register bits [8k+7:8k].
- R6: When command bit 8 is 0, the data phase sends 0x00 bytes. Received byte k is stored in data register bits [8k+7:8k], and the other bytes of the data register are left unchanged. Received bits are taken on the rising edge of the serial clock, and the output changes only after a falling edge.
- R7: The status pending bit (bit 22) goes to 1 when a command is accepted. It clears only after the final byte has been stored.
- R8: Command bits [26:24] choose which `flash_cs_n` bit is driven low during the command. At most one chip-select output is low at any time.
- R9: When command bit 15 is 1, the chip select stays low after the command. The next command then leaves out its opcode byte and goes directly to its address, dummy and data bytes.
- R10: A command with bit 15 clear ends the frame. If it has no bytes to send (opcode left out and all lengths zero), it raises the chip select without producing any clock pulses.
- R11: Writing the command register while pending is 1 sets the error bit (status bit 29) and discards the new command.
- R12: Writing status with bit 29 set clears the error bit. Writing status with bit 29 clear leaves the error bit unchanged.
- R13: The serial clock pulses low only while a chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 2 | Register select: 0 command, 1 address, 2 data, 3 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| flash_cs_n | output | 8 | Chip selects, active low |
| flash_sck | output | 1 | Serial clock, idles high |
| flash_mosi | output | 1 | Serial data to the flash |
| flash_miso | input | 1 | Serial data from the flash |

## Verification
The assertions assume that software writes the address and data registers only while no command is pending. They also assume that `reg_we` pulses for one cycle per access with a stable `reg_addr`, and that `flash_miso` is steady around the rising edge of the serial clock. The bench keeps within these limits. It loads the address and data registers before each command word, and it writes only the command or status register while a command is in flight. Its flash model changes `flash_miso` on falling clock edges only, and it takes every outgoing bit on the rising edge.

// File: rtl/fcs_pkg.sv
`timescale 1ns/1ps
// Package fcs_pkg
// Shared encodings for the serial flash command sequencer: register offsets,
// command word field positions, status bit positions and the sequencer types.
// Assumes a 32-bit register port.
package fcs_pkg;

    // register offsets on the two-bit register address
    localparam logic [1:0] REG_CMD  = 2'd0;
    localparam logic [1:0] REG_ADDR = 2'd1;
    localparam logic [1:0] REG_DATA = 2'd2;
    localparam logic [1:0] REG_STAT = 2'd3;

    // status bit positions
    localparam int STAT_PEND_BIT = 22;
    localparam int STAT_ERR_BIT  = 29;

    // command field widths
    localparam int OPC_W  = 8;
    localparam int DLEN_W = 3;
    localparam int DUM_W  = 4;
    localparam int ALEN_W = 3;
    localparam int CSN_W  = 3;

    // decoded command word
    typedef struct packed {
        logic [CSN_W-1:0]  cs;
        logic [ALEN_W-1:0] alen;
        logic [DUM_W-1:0]  dum;
        logic              keep;
        logic [DLEN_W-1:0] dlen;
        logic              wr;
        logic [OPC_W-1:0]  opc;
    } cmd_t;

    // sequencer state
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_SHIFT = 2'd2
    } seq_state_t;

endpackage

// File: rtl/fcs_bitclk.sv
`timescale 1ns/1ps
// Module fcs_bitclk
// Bit timing generator. While run is high it produces 8 serial clock periods
// per byte. Each period is HALF_DIV cycles low followed by HALF_DIV cycles high.
// The shift strobe marks the first low cycle. The sample strobe marks the first
// high cycle. byte_done marks the final cycle of the eighth bit.
// Assumes HALF_DIV >= 2, so that the last sample comes before byte_done.
module fcs_bitclk #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sck,
    output logic shift_stb,
    output logic sample_stb,
    output logic byte_done
);
    localparam int PER  = 2 * HALF_DIV;
    localparam int CW   = (PER > 2) ? $clog2(PER) : 1;

    logic [CW-1:0] cnt;
    logic [2:0]    bitn;

    // period counter and bit counter, held at zero while idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            bitn <= '0;
        end else if (!run) begin
            cnt  <= '0;
            bitn <= '0;
        end else if (cnt == CW'(PER - 1)) begin
            cnt  <= '0;
            bitn <= bitn + 3'd1;
        end else begin
            cnt  <= cnt + CW'(1);
        end
    end

    // strobe and clock decode
    always_comb begin
        shift_stb  = run && (cnt == '0);
        sample_stb = run && (cnt == CW'(HALF_DIV));
        byte_done  = run && (cnt == CW'(PER - 1)) && (bitn == 3'd7);
        sck        = !(run && (cnt < CW'(HALF_DIV)));
    end

    // R13
    // a falling edge (shift strobe) only ever follows a high clock
    fall_after_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_stb |-> $past(sck));

endmodule

// File: rtl/fcs_shift.sv
`timescale 1ns/1ps
// Module fcs_shift
// Byte shifter for one serial lane. load fills it with the byte to send. On
// each shift strobe the top bit goes to mosi. On each sample strobe miso enters
// at the bottom. After eight bits the register holds the received byte.
// Assumes the shift and sample strobes never fire in the same cycle.
module fcs_shift (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] load_byte,
    input  logic       shift_stb,
    input  logic       sample_stb,
    input  logic       miso,
    output logic       mosi,
    output logic [7:0] rx_byte
);
    logic [7:0] sreg;

    // load, drive and capture, most significant bit first
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg <= '0;
            mosi <= 1'b0;
        end else if (load) begin
            sreg <= load_byte;
        end else begin
            if (shift_stb)  mosi <= sreg[7];
            if (sample_stb) sreg <= {sreg[6:0], miso};
        end
    end

    assign rx_byte = sreg;

    // R6
    // the serial output only moves right after a falling-edge strobe
    mosi_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mosi) |-> $past(shift_stb));

endmodule

// File: rtl/fcs_seq.sv
`timescale 1ns/1ps
// Module fcs_seq
// Command sequencer. A start pulse latches a decoded command. The sequencer then
// hands bytes to the shifter one by one: opcode (left out while a frame is
// held), address bytes highest first, zero dummy bytes, then the data bytes.
// Received data bytes are reported per lane. When no byte is left, the frame
// state is updated from the keep bit and the sequencer returns to idle.
// Assumes start only arrives while idle, and that the address and data words
// are stable while busy.
module fcs_seq
    import fcs_pkg::*;
#(
    parameter int ADDR_BYTES = 3,
    parameter int DATA_BYTES = 4,
    localparam int AL_W = $clog2(ADDR_BYTES + 1),
    localparam int DL_W = $clog2(DATA_BYTES + 1),
    localparam int DI_W = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  cmd_t                    cmd_in,
    input  logic [8*ADDR_BYTES-1:0] addr_word,
    input  logic [8*DATA_BYTES-1:0] data_word,
    input  logic                    byte_done,
    output logic                    run,
    output logic                    load,
    output logic [7:0]              load_byte,
    output logic                    busy,
    output logic                    frame_open,
    output logic [CSN_W-1:0]        cs_idx,
    output logic                    rx_we,
    output logic [DI_W-1:0]         rx_lane
);
    seq_state_t        state;
    logic              opc_left;
    logic [AL_W-1:0]   addr_left;
    logic [DUM_W-1:0]  dum_left;
    logic [DL_W-1:0]   data_left;
    logic [DI_W-1:0]   data_idx;
    logic              ph_data;
    logic              wr_q;
    logic              keep_q;
    logic [OPC_W-1:0]  opc_q;
    logic [CSN_W-1:0]  cs_q;
    logic              open_q;
    logic [AL_W-1:0]   alen_c;
    logic [DL_W-1:0]   dlen_c;

    // clamp the requested lengths to the register sizes
    always_comb begin
        alen_c = (int'(cmd_in.alen) > ADDR_BYTES) ? AL_W'(ADDR_BYTES) : AL_W'(cmd_in.alen);
        dlen_c = (int'(cmd_in.dlen) > DATA_BYTES) ? DL_W'(DATA_BYTES) : DL_W'(cmd_in.dlen);
    end

    // pick the next byte to send, in phase priority order
    always_comb begin
        load      = 1'b0;
        load_byte = 8'h00;
        if (state == ST_LOAD) begin
            if (opc_left) begin
                load      = 1'b1;
                load_byte = opc_q;
            end else if (addr_left != '0) begin
                load      = 1'b1;
                load_byte = addr_word[8*(int'(addr_left)-1) +: 8];
            end else if (dum_left != '0) begin
                load      = 1'b1;
                load_byte = 8'h00;
            end else if (data_left != '0) begin
                load      = 1'b1;
                load_byte = wr_q ? data_word[8*int'(data_idx) +: 8] : 8'h00;
            end
        end
    end

    // phase counters and state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            opc_left  <= 1'b0;
            addr_left <= '0;
            dum_left  <= '0;
            data_left <= '0;
            data_idx  <= '0;
            ph_data   <= 1'b0;
            wr_q      <= 1'b0;
            keep_q    <= 1'b0;
            opc_q     <= '0;
            cs_q      <= '0;
            open_q    <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        opc_left  <= !open_q;
                        addr_left <= alen_c;
                        dum_left  <= cmd_in.dum;
                        data_left <= dlen_c;
                        data_idx  <= '0;
                        wr_q      <= cmd_in.wr;
                        keep_q    <= cmd_in.keep;
                        opc_q     <= cmd_in.opc;
                        cs_q      <= cmd_in.cs;
                        state     <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    ph_data <= 1'b0;
                    if (opc_left) begin
                        opc_left <= 1'b0;
                        state    <= ST_SHIFT;
                    end else if (addr_left != '0) begin
                        addr_left <= addr_left - AL_W'(1);
                        state     <= ST_SHIFT;
                    end else if (dum_left != '0) begin
                        dum_left <= dum_left - DUM_W'(1);
                        state    <= ST_SHIFT;
                    end else if (data_left != '0) begin
                        data_left <= data_left - DL_W'(1);
                        ph_data   <= 1'b1;
                        state     <= ST_SHIFT;
                    end else begin
                        open_q <= keep_q;
                        state  <= ST_IDLE;
                    end
                end
                ST_SHIFT: begin
                    if (byte_done) begin
                        if (ph_data) data_idx <= data_idx + DI_W'(1);
                        state <= ST_LOAD;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // outputs toward the timing generator, shifter and register file
    always_comb begin
        run        = (state == ST_SHIFT);
        busy       = (state != ST_IDLE);
        frame_open = open_q;
        cs_idx     = cs_q;
        rx_we      = (state == ST_SHIFT) && byte_done && ph_data && !wr_q;
        rx_lane    = data_idx;
    end

    // R11
    // the register file must never start a command while one is running
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

endmodule

// File: rtl/flash_cmd_seq.sv
`timescale 1ns/1ps
// Module flash_cmd_seq
// Top of the serial flash command sequencer. It holds the command, address,
// data and status registers. It starts a command on a command write while idle,
// flags an error on a command write while busy, and drives the chip selects from
// the sequencer's frame state.
// Assumes one-cycle register write strobes and no address or data register
// writes while a command is pending.
module flash_cmd_seq
    import fcs_pkg::*;
#(
    parameter int ADDR_BYTES = 3,
    parameter int DATA_BYTES = 4,
    parameter int HALF_DIV   = 2,
    localparam int CS_NUM    = 1 << CSN_W,
    localparam int DI_W      = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [CS_NUM-1:0] flash_cs_n,
    output logic              flash_sck,
    output logic              flash_mosi,
    input  logic              flash_miso
);
    logic [31:0]             cmd_q;
    logic [8*ADDR_BYTES-1:0] addr_q;
    logic [8*DATA_BYTES-1:0] data_q;
    logic [7:0]              data_lane [DATA_BYTES];
    logic                    err_q;
    cmd_t                    cmd_dec;
    logic                    cmd_wr, stat_wr, addr_wr, data_wr, start;
    logic                    busy, frame_open, run, load, rx_we;
    logic                    shift_stb, sample_stb, byte_done;
    logic [7:0]              load_byte, rx_byte;
    logic [CSN_W-1:0]        cs_idx;
    logic [DI_W-1:0]         rx_lane;
    logic [31:0]             stat_word;

    // write decode and command field split
    always_comb begin
        cmd_wr  = reg_we && (reg_addr == REG_CMD);
        addr_wr = reg_we && (reg_addr == REG_ADDR);
        data_wr = reg_we && (reg_addr == REG_DATA);
        stat_wr = reg_we && (reg_addr == REG_STAT);
        start   = cmd_wr && !busy;
        cmd_dec.opc  = reg_wdata[7:0];
        cmd_dec.wr   = reg_wdata[8];
        cmd_dec.dlen = reg_wdata[11:9];
        cmd_dec.keep = reg_wdata[15];
        cmd_dec.dum  = reg_wdata[19:16];
        cmd_dec.alen = reg_wdata[22:20];
        cmd_dec.cs   = reg_wdata[26:24];
    end

    // command and address registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            addr_q <= '0;
        end else begin
            if (start)   cmd_q  <= reg_wdata;
            if (addr_wr) addr_q <= reg_wdata[8*ADDR_BYTES-1:0];
        end
    end

    // error flag: set by a refused command, cleared by writing one to it
    always_ff @(posedge clk) begin
        if (!rst_n)                                err_q <= 1'b0;
        else if (cmd_wr && busy)                   err_q <= 1'b1;
        else if (stat_wr && reg_wdata[STAT_ERR_BIT]) err_q <= 1'b0;
    end

    // data register lanes, received bytes win over software writes
    for (genvar k = 0; k < DATA_BYTES; k++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n)
                data_lane[k] <= '0;
            else if (rx_we && (rx_lane == DI_W'(k)))
                data_lane[k] <= rx_byte;
            else if (data_wr)
                data_lane[k] <= reg_wdata[8*k +: 8];
        end
        assign data_q[8*k +: 8] = data_lane[k];
    end

    // status word and read mux
    always_comb begin
        stat_word                = '0;
        stat_word[STAT_PEND_BIT] = busy;
        stat_word[STAT_ERR_BIT]  = err_q;
        case (reg_addr)
            REG_CMD:  reg_rdata = cmd_q;
            REG_ADDR: reg_rdata = 32'(addr_q);
            REG_DATA: reg_rdata = 32'(data_q);
            default:  reg_rdata = stat_word;
        endcase
    end

    // chip select decode
    for (genvar i = 0; i < CS_NUM; i++) begin : g_cs
        assign flash_cs_n[i] = !((busy || frame_open) && (cs_idx == CSN_W'(i)));
    end

    fcs_seq #(
        .ADDR_BYTES (ADDR_BYTES),
        .DATA_BYTES (DATA_BYTES)
    ) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .cmd_in     (cmd_dec),
        .addr_word  (addr_q),
        .data_word  (data_q),
        .byte_done  (byte_done),
        .run        (run),
        .load       (load),
        .load_byte  (load_byte),
        .busy       (busy),
        .frame_open (frame_open),
        .cs_idx     (cs_idx),
        .rx_we      (rx_we),
        .rx_lane    (rx_lane)
    );

    fcs_bitclk #(
        .HALF_DIV (HALF_DIV)
    ) clk_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .sck        (flash_sck),
        .shift_stb  (shift_stb),
        .sample_stb (sample_stb),
        .byte_done  (byte_done)
    );

    fcs_shift shift_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_byte  (load_byte),
        .shift_stb  (shift_stb),
        .sample_stb (sample_stb),
        .miso       (flash_miso),
        .mosi       (flash_mosi),
        .rx_byte    (rx_byte)
    );

    // R8
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~flash_cs_n));

    // R13
    sck_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_sck |-> !(&flash_cs_n));

    // R11
    busy_cmd_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && busy) |=> err_q);

    // R12
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && reg_wdata[STAT_ERR_BIT]) |=> !err_q);

endmodule

// File: tb/flash_cmd_seq_tb_top.sv
`timescale 1ns/1ps
// Bench for flash_cmd_seq: a vector table walked by one loop, then directed
// tests for reset, error handling and frame chaining. A behavioural flash model
// records each byte on the wire and returns a known byte stream.
module flash_cmd_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  flash_cs_n;
    logic        flash_sck;
    logic        flash_mosi;
    logic        flash_miso = 1'b0;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    flash_cmd_seq dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .flash_cs_n (flash_cs_n),
        .flash_sck  (flash_sck),
        .flash_mosi (flash_mosi),
        .flash_miso (flash_miso)
    );

    // ---------------- flash model ----------------
    logic [7:0] cap    [256];
    logic [2:0] cap_cs [256];
    int         cap_n = 0;
    int         bitn = 0;
    int         frame_bits = 0;
    logic [7:0] sh = 8'h00;
    logic [7:0] rb;
    logic       cs_idle;

    assign cs_idle = &flash_cs_n;

    function automatic logic [7:0] resp_byte(input int i);
        return 8'((i * 29 + 90) & 255);
    endfunction

    function automatic logic [2:0] low_cs(input logic [7:0] v);
        logic [2:0] r = 3'd0;
        for (int i = 0; i < 8; i++) if (!v[i]) r = 3'(i);
        return r;
    endfunction

    always @(posedge flash_sck or posedge cs_idle) begin
        if (cs_idle) begin
            bitn       = 0;
            frame_bits = 0;
        end else begin
            sh = {sh[6:0], flash_mosi};
            bitn++;
            frame_bits++;
            if (bitn == 8) begin
                cap[cap_n]    = sh;
                cap_cs[cap_n] = low_cs(flash_cs_n);
                cap_n++;
                bitn = 0;
            end
        end
    end

    always @(negedge flash_sck) begin
        rb = resp_byte(frame_bits / 8);
        flash_miso <= rb[7 - (frame_bits % 8)];
    end

    // ---------------- helpers ----------------
    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        bit done = 0;
        for (int i = 0; i < 4000 && !done; i++) begin
            reg_read(2'd3, s);
            if (!s[22]) done = 1;
        end
        if (!done) check("R7 pending never cleared", 32'd1, 32'd0);
    endtask

    // issue one command and compare the wire bytes and read data with a model
    task automatic run_cmd(input logic [31:0] cmd, input logic [31:0] addr,
                           input logic [31:0] wdata, input int exp_cnt,
                           input bit skip_opc, input int pos0, input string tag);
        logic [7:0]  exp_b [32];
        logic [31:0] exp_rd, rd;
        int n = 0, al, dl, dm, st, pre, bad;
        al = (cmd[22:20] > 3) ? 3 : int'(cmd[22:20]);
        dl = (cmd[11:9]  > 4) ? 4 : int'(cmd[11:9]);
        dm = int'(cmd[19:16]);
        if (!skip_opc) begin exp_b[n] = cmd[7:0]; n++; end
        for (int a = al - 1; a >= 0; a--) begin exp_b[n] = addr[8*a +: 8]; n++; end
        for (int d = 0; d < dm; d++) begin exp_b[n] = 8'h00; n++; end
        pre = n;
        exp_rd = wdata;
        for (int k = 0; k < dl; k++) begin
            exp_b[n] = cmd[8] ? wdata[8*k +: 8] : 8'h00;
            n++;
            if (!cmd[8]) exp_rd[8*k +: 8] = resp_byte(pos0 + pre + k);
        end
        reg_write(2'd1, addr);
        reg_write(2'd2, wdata);
        st = cap_n;
        reg_write(2'd0, cmd);
        wait_idle();
        check({tag, " byte count"}, 32'(cap_n - st), 32'(exp_cnt));
        bad = -1;
        for (int i = 0; i < n; i++)
            if (bad < 0 && (cap[st+i] !== exp_b[i] || cap_cs[st+i] !== cmd[26:24])) bad = i;
        if (bad >= 0)
            check({tag, " wire byte/cs"}, {21'd0, cap_cs[st+bad], cap[st+bad]},
                  {21'd0, cmd[26:24], exp_b[bad]});
        else
            check({tag, " wire bytes"}, 32'd0, 32'd0);
        if (!cmd[8] && dl > 0) begin
            reg_read(2'd2, rd);
            check({tag, " R6 read data"}, rd, exp_rd);
        end
    endtask

    // cmd, addr, wdata, expected byte count on the wire
    localparam logic [103:0] VEC [7] = '{
        {32'h0000069F, 32'h00000000, 32'h00000000, 8'd4},
        {32'h01300902, 32'h00123456, 32'hDDCCBBAA, 8'd8},
        {32'h0231080B, 32'h00ABCDEF, 32'h55555555, 8'd9},
        {32'h0722035A, 32'h0000BEEF, 32'h11223344, 8'd6},
        {32'h03700F33, 32'h00A1B2C3, 32'h87654321, 8'd8},
        {32'h04000006, 32'h00000000, 32'h00000000, 8'd1},
        {32'h051F04EB, 32'h00000077, 32'h0F0F0F0F, 8'd19}
    };

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired: actual hang expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        logic [31:0] rd;
        int st;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_read(2'd3, rd);
        check("R1 status after reset", rd, 32'h0);
        check("R1 chip selects after reset", 32'(flash_cs_n), 32'hFF);
        check("R1 sck/mosi after reset", {30'd0, flash_sck, flash_mosi}, 32'h2);

        // R2 register read-back
        reg_write(2'd1, 32'hFFFFFFFF);
        reg_read(2'd1, rd);
        check("R2 address read-back", rd, 32'h00FFFFFF);
        reg_write(2'd2, 32'h89ABCDEF);
        reg_read(2'd2, rd);
        check("R2 data read-back", rd, 32'h89ABCDEF);

        // table: R3 R4 R5 R6 R8 R13 across several shapes
        for (int i = 0; i < 7; i++) begin
            logic [103:0] v;
            v = VEC[i];
            run_cmd(v[103:72], v[71:40], v[39:8], int'(v[7:0]), 1'b0, 0, "R3 R4 R5 R8 vector");
            check("R10 frame closed after vector", 32'(flash_cs_n), 32'hFF);
        end

        // R11 command while pending; R7 pending set
        st = cap_n;
        reg_write(2'd0, 32'h00000006);
        reg_write(2'd0, 32'h000000C7);
        reg_read(2'd3, rd);
        check("R7 pending after accept", 32'(rd[22]), 32'd1);
        wait_idle();
        check("R11 refused command left no bytes", 32'(cap_n - st), 32'd1);
        check("R11 first opcode on wire", 32'(cap[st]), 32'h06);
        reg_read(2'd3, rd);
        check("R11 error bit set", rd, 32'h20000000);
        reg_read(2'd0, rd);
        check("R2 R11 command read-back keeps accepted", rd, 32'h00000006);

        // R12 error clear
        reg_write(2'd3, 32'h00000000);
        reg_read(2'd3, rd);
        check("R12 write zero keeps error", rd, 32'h20000000);
        reg_write(2'd3, 32'h20000000);
        reg_read(2'd3, rd);
        check("R12 write one clears error", rd, 32'h0);

        // R9 chained frame on chip select 6, R10 closing command
        run_cmd(32'h0630800B, 32'h00010203, 32'h0, 4, 1'b0, 0, "R9 head");
        check("R9 frame held", 32'(flash_cs_n), 32'hBF);
        run_cmd(32'h060088FF, 32'h0, 32'hFFFFFFFF, 4, 1'b1, 4, "R9 opcode skipped");
        check("R9 frame still held", 32'(flash_cs_n), 32'hBF);
        run_cmd(32'h06000000, 32'h0, 32'h0, 0, 1'b1, 8, "R10 empty close");
        check("R10 frame closed", 32'(flash_cs_n), 32'hFF);
        check("R13 clock idle high", 32'(flash_sck), 32'd1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule